// File: doc/BRIEF.md
# Transport Stream Energy Dispersal Descrambler

This block removes the energy-dispersal scrambling from a byte-serial broadcast transport stream. It sits after the Reed-Solomon decoder. Each byte arrives with a valid strobe and three qualifiers: start of block, sync byte and check byte. The block XORs message bytes with the output of a 15-stage pseudo-random generator. The generator restarts from a programmable 15-bit seed whenever an inverted sync byte arrives, and that byte marks the head of an eight-block superframe.

Sync bytes and Reed-Solomon check bytes leave the block unchanged. A non-inverted sync byte still clocks the generator by one byte's worth of steps, but that generator output is thrown away. A check byte does not advance the generator at all. A check byte is either flagged at the input or sits at or beyond the programmable message length within its block. A bypass input lets data through unchanged. Every byte leaves the block one clock after it arrives, with its qualifiers delayed by the same amount.

Top module: `edd_descrambler`

## Requirements
- R1: The generator's feedback is the XOR of stage 14 and stage 15, which shifts into stage 1. A message byte is XORed with the next 8 feedback bits, the first of them going to bit 7 (MSB). The generator then advances by 8 steps.
- R2: A byte with the sync qualifier and the value 0xB8 loads the generator from `seed_i`, where `seed_i[k-1]` is stage k. It is not advanced on that byte, so the byte that follows uses the first 8 outputs of the new seed.
- R3: A byte with the sync qualifier and any value other than 0xB8 advances the generator by 8 steps, and its output is not applied.
- R4: A non-sync byte is a check byte if `par_i` is high or if its position in the block is at least `msg_len_i`. A check byte leaves unchanged, drives `par_o` high and does not advance the generator.
- R5: Every sync byte leaves unchanged.
- R6: Each valid input byte appears on the outputs exactly one clock later. The outputs carry `sob_o` and `sync_o` equal to the inputs, and `valid_o` is low one clock after a cycle with no valid input.
- R7: While `bypass_i` is high, a message byte leaves unchanged, and the generator still advances as if it had been descrambled.
- R8: After reset, `valid_o` is low and the generator holds the default seed 100101010000000 (stage 1 first). A message byte sent before any inverted sync uses that seed, so 0x00 becomes 0x03.
- R9: The position is 0 on a byte with `sob_i` high and counts up by one per valid byte. It saturates at its maximum (255) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_i | input | 15 | Generator seed, bit k-1 is stage k |
| msg_len_i | input | 8 | Message bytes per block, sync byte included |
| bypass_i | input | 1 | Pass message bytes unchanged |
| valid_i | input | 1 | Input byte valid |
| data_i | input | 8 | Input byte |
| sob_i | input | 1 | First byte of a block |
| sync_i | input | 1 | Byte is a sync byte |
| par_i | input | 1 | Byte is a check byte |
| valid_o | output | 1 | Output byte valid |
| data_o | output | 8 | Descrambled byte |
| sob_o | output | 1 | First byte of a block |
| sync_o | output | 1 | Byte is a sync byte |
| par_o | output | 1 | Byte was treated as a check byte |

## Verification
The bench builds the block with its default parameters: a 15-stage generator, an 8-bit position counter, inverted sync 0xB8 and the standard default seed. Most blocks are 16 bytes long with `msg_len_i` between 4 and 15. Short blocks bring whole superframe reloads, the parity region and seed changes within a few hundred cycles. One 188-message-byte block covers the full broadcast length. A 300-byte stream without a start of block drives the position counter into saturation.

// File: rtl/edd_pkg.sv
package edd_pkg;
  localparam int LFSR_W = 15;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_MSG  = 2'd0,
    CLS_PAR  = 2'd1,
    CLS_RUN  = 2'd2,
    CLS_LOAD = 2'd3
  } byte_cls_e;
endpackage

// File: rtl/edd_prbs.sv
module edd_prbs
  import edd_pkg::*;
#(
  parameter int          W        = LFSR_W,
  parameter int          TAP_LO   = 14,
  parameter int          TAP_HI   = 15,
  parameter int          STEPS    = BYTE_W,
  parameter logic [W-1:0] DEF_SEED = 15'h00A9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [W-1:0]     seed_i,
  output logic [STEPS-1:0] mask_o
);
  logic [W-1:0]     st_q;
  logic [W-1:0]     chain [STEPS+1];
  logic [STEPS-1:0] bits;

  assign chain[0] = st_q;

  // unrolled shifts; first feedback bit lands in the mask MSB
  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign bits[STEPS-1-k] = chain[k][TAP_LO-1] ^ chain[k][TAP_HI-1];
    assign chain[k+1]      = {chain[k][W-2:0], bits[STEPS-1-k]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= DEF_SEED;
    else if (load_i) st_q <= seed_i;
    else if (adv_i)  st_q <= chain[STEPS];
  end

  assign mask_o = bits;
endmodule

// File: rtl/edd_pos.sv
module edd_pos #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sob_i,
  input  logic [CNT_W-1:0] msg_len_i,
  output logic             past_msg_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, pos;

  assign pos        = sob_i ? '0 : cnt_q;
  assign past_msg_o = (pos >= msg_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= (pos == CNT_MAX) ? pos : pos + 1'b1;
  end
endmodule

// File: rtl/edd_descrambler.sv
module edd_descrambler
  import edd_pkg::*;
#(
  parameter int               CNT_W    = 8,
  parameter logic [BYTE_W-1:0] SYNC_INV = 8'hB8,
  parameter logic [LFSR_W-1:0] DEF_SEED = 15'h00A9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [CNT_W-1:0]  msg_len_i,
  input  logic              bypass_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              sob_i,
  input  logic              sync_i,
  input  logic              par_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              sob_o,
  output logic              sync_o,
  output logic              par_o
);
  logic              past_msg;
  logic [BYTE_W-1:0] mask;
  byte_cls_e         cls;
  logic              gen_load, gen_adv;

  edd_pos #(.CNT_W(CNT_W)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .sob_i      (sob_i),
    .msg_len_i  (msg_len_i),
    .past_msg_o (past_msg)
  );

  always_comb begin
    if (sync_i)                cls = (data_i == SYNC_INV) ? CLS_LOAD : CLS_RUN;
    else if (par_i || past_msg) cls = CLS_PAR;
    else                       cls = CLS_MSG;
  end

  assign gen_load = valid_i && (cls == CLS_LOAD);
  assign gen_adv  = valid_i && (cls == CLS_RUN || cls == CLS_MSG);

  edd_prbs #(
    .W        (LFSR_W),
    .STEPS    (BYTE_W),
    .DEF_SEED (DEF_SEED)
  ) u_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gen_load),
    .adv_i  (gen_adv),
    .seed_i (seed_i),
    .mask_o (mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sob_o   <= 1'b0;
      sync_o  <= 1'b0;
      par_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= (cls == CLS_MSG && !bypass_i) ? (data_i ^ mask) : data_i;
        sob_o  <= sob_i;
        sync_o <= sync_i;
        par_o  <= (cls == CLS_PAR);
      end
    end
  end
endmodule

// File: rtl/edd_descrambler_chk.sv
module edd_descrambler_chk
  import edd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bypass_i,
  input logic              valid_i,
  input logic [BYTE_W-1:0] data_i,
  input logic              sob_i,
  input logic              sync_i,
  input logic              par_i,
  input logic              valid_o,
  input logic [BYTE_W-1:0] data_o,
  input logic              sob_o,
  input logic              sync_o,
  input logic              par_o
);
  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r6_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r6_quals_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (sob_o == $past(sob_i)) && (sync_o == $past(sync_i)));
  a_r5_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sync_i |=> data_o == $past(data_i));
  a_r4_par_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && par_i && !sync_i |=> par_o && (data_o == $past(data_i)));
  a_r7_bypass_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && bypass_i |=> data_o == $past(data_i));
endmodule

bind edd_descrambler edd_descrambler_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/edd_descrambler_bench.sv
module edd_descrambler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] seed = 15'h00A9;
  logic [7:0]  msg_len = 8'd12;
  logic        bypass = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = '0;
  logic        sob = 1'b0, sync = 1'b0, par = 1'b0;
  logic        valid_o, sob_o, sync_o, par_o;
  logic [7:0]  data_o;

  int compared = 0, mismatched = 0;

  // reference model state: m_gen[k-1] is stage k
  logic [14:0] m_gen = 15'h00A9;
  int          m_pos = 0;

  always #2.5 clk = ~clk;

  edd_descrambler u_edd_descrambler (
    .clk_i(clk), .rst_ni(rst_n), .seed_i(seed), .msg_len_i(msg_len),
    .bypass_i(bypass), .valid_i(valid), .data_i(data), .sob_i(sob),
    .sync_i(sync), .par_i(par), .valid_o(valid_o), .data_o(data_o),
    .sob_o(sob_o), .sync_o(sync_o), .par_o(par_o)
  );

  function automatic logic [7:0] gen_byte(logic [14:0] s);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      b[i] = s[13] ^ s[14];
      s    = {s[13:0], b[i]};
    end
    return b;
  endfunction

  function automatic logic [14:0] gen_next(logic [14:0] s);
    for (int i = 0; i < 8; i++) s = {s[13:0], s[13] ^ s[14]};
    return s;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic s_ob, logic s_y, logic p, logic byp);
    logic [7:0] exp_d;
    logic       exp_p;
    int         pos;
    string      req;
    @(negedge clk);
    valid = 1'b1; data = d; sob = s_ob; sync = s_y; par = p; bypass = byp;
    pos   = s_ob ? 0 : m_pos;
    exp_p = 1'b0;
    if (s_y && d == 8'hB8) begin
      req = "R2"; exp_d = d; m_gen = seed;
    end else if (s_y) begin
      req = "R3"; exp_d = d; m_gen = gen_next(m_gen);
    end else if (p || pos >= msg_len) begin
      req = "R4"; exp_d = d; exp_p = 1'b1;
    end else begin
      req   = byp ? "R7" : "R1";
      exp_d = byp ? d : d ^ gen_byte(m_gen);
      m_gen = gen_next(m_gen);
    end
    m_pos = (pos == 255) ? 255 : pos + 1;
    @(posedge clk); #1;
    check(req, {valid_o, sob_o, sync_o, exp_p ? 5'h1f : 5'h00, data_o},
          {1'b1, s_ob, s_y, exp_p ? 5'h1f : 5'h00, exp_d});
    check({req, "/R6"}, {12'h0, valid_o, sob_o, sync_o, par_o},
          {12'h0, 1'b1, s_ob, s_y, exp_p});
  endtask

  task automatic send_block(logic inv, int len, bit rnd);
    send(inv ? 8'hB8 : 8'h47, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 1; i < len; i++)
      send(rnd ? 8'($urandom) : 8'h00, 1'b0, 1'b0,
           rnd ? ($urandom % 8 == 0) : 1'b0,
           rnd ? ($urandom % 6 == 0) : 1'b0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    check("R8", {15'h0, valid_o}, 16'h0);
    rst_n = 1'b1;
    // R8: default seed before any reload, 0x00 -> 0x03
    send(8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8", {8'h0, data_o}, 16'h0003);
    // R2/R1: reload then first message byte
    send(8'hB8, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R1", {8'h0, data_o}, 16'h0003);
    // R6: idle gap
    @(negedge clk); valid = 1'b0;
    @(posedge clk); #1;
    check("R6", {15'h0, valid_o}, 16'h0);
    // directed superframe, msg_len 12, block 16
    msg_len = 8'd12;
    for (int b = 0; b < 8; b++) send_block(b == 0, 16, 1'b0);
    // random superframes with seed changes
    for (int f = 0; f < 6; f++) begin
      @(negedge clk);
      seed    = 15'($urandom);
      msg_len = 8'(4 + $urandom % 12);
      for (int b = 0; b < 8; b++) send_block(b == 0, 16, 1'b1);
    end
    // full-length block
    seed = 15'h00A9; msg_len = 8'd188;
    send_block(1'b1, 204, 1'b1);
    // R9: long run without start of block stays parity after 255
    msg_len = 8'd12;
    send(8'h47, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) send(8'($urandom), 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", {15'h0, par_o}, 16'h1);
    @(negedge clk); valid = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule